// File: doc/BRIEF.md
# Core Register File with Mapped Special Registers

This block is the 512-word by 32-bit register file of one processor core. It has two combinational read ports, one for the source operand and one for the destination operand, and a single clocked write port for instruction results. Most of the address space is plain storage. The top sixteen words are special. Four of them return live hardware values that the core samples: the free-running counter, a random value and the two input-pin banks. Eight of them behave as RAM, and each write to one of these also updates a peripheral register of the same index. Two of them stand for the phase accumulators of the peripheral. The last two are indirect slots that redirect an access through one of two 9-bit pointer registers.

The storage cells that sit beneath the four live addresses and beneath the phase and indirect addresses can never be reached by instructions. They are reused to hold two four-word cache lines: a data line and an instruction line. A separate background write port fills these lines, and it can write in the same cycle as an instruction. Both lines are always visible on wide outputs for the fetch and load logic.

Top module: `core_regfile`

## Requirements
- R1: Addresses 0x000 to 0x1EF are plain storage. A write on the write port is visible on both read ports from the next cycle, and reads are combinational.
- R2: A read of 0x1F0, 0x1F1, 0x1F2 or 0x1F3 returns live_cnt, live_rnd, live_ina or live_inb, in that order. An instruction write to these addresses has no effect, and the data cache line beneath them stays unchanged.
- R3: A read of 0x1F4 to 0x1FB returns the storage word. A write updates that word and also the peripheral register k = address − 0x1F4, which is shown on shadow_regs[32k+31:32k].
- R4: A read of 0x1FC returns phase_a and a read of 0x1FD returns phase_b. During the cycle of a write to one of them, phs_wr_en is 2'b01 for 0x1FC or 2'b10 for 0x1FD, and phs_wr_data carries the written value. The instruction cache cells are not changed.
- R5: An access to 0x1FE goes through pointer A and an access to 0x1FF goes through pointer B, for both reads and writes. The same rules then apply to the address the pointer holds.
- R6: When the selected pointer holds 0x1FE or 0x1FF, a read returns zero and a write has no effect on any state or output.
- R7: Pointer A loads ptr_ld_val on a clock edge when ptr_ld_en[0] is set. Pointer B loads it when ptr_ld_en[1] is set.
- R8: A background write with bg_line=0 writes word bg_word of the data line (cells 0x1F0+word). With bg_line=1 it writes the instruction line (cells 0x1FC+word). Word w of each line appears on bits [32w+31:32w] of dcache_line or icache_line. A background write and an instruction write in the same cycle both take effect.
- R9: After reset, all storage, all shadow registers and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_addr | input | 9 | Source read address |
| src_data | output | 32 | Source read data |
| dst_addr | input | 9 | Destination read address |
| dst_data | output | 32 | Destination read data |
| wr_en | input | 1 | Instruction write enable |
| wr_addr | input | 9 | Instruction write address |
| wr_data | input | 32 | Instruction write data |
| live_cnt | input | 32 | Counter value |
| live_rnd | input | 32 | Random value |
| live_ina | input | 32 | Input pin bank A |
| live_inb | input | 32 | Input pin bank B |
| phase_a | input | 32 | Phase accumulator A |
| phase_b | input | 32 | Phase accumulator B |
| phs_wr_en | output | 2 | Phase write strobes (bit0 A, bit1 B) |
| phs_wr_data | output | 32 | Phase write value |
| shadow_regs | output | 256 | Eight peripheral registers, index k at bits 32k+31:32k |
| ptr_ld_en | input | 2 | Pointer load enables (bit0 A, bit1 B) |
| ptr_ld_val | input | 9 | Pointer load value |
| bg_wr_en | input | 1 | Background cache write enable |
| bg_line | input | 1 | 0 data line, 1 instruction line |
| bg_word | input | 2 | Word within the line |
| bg_wr_data | input | 32 | Background write data |
| dcache_line | output | 128 | Data cache line, word 0 lowest |
| icache_line | output | 128 | Instruction cache line, word 0 lowest |

## Verification
The bench goes after the borders between the address regions: 0x1EF against 0x1F0, 0x1F3 against 0x1F4, and 0x1FB against 0x1FC. A decoder that is off by one there would either let a write reach a live address and corrupt a cache word, or drop the shadow update of the last peripheral register. Indirect accesses are run through pointers that land in each region, including pointers that point back at the indirect slots. A design that followed those pointers again would return storage or live data where zero is required, or would write a cache cell. Background writes in the same cycle as instruction writes show whether the two write ports block each other. Reads of the phase and live addresses with changing side-band inputs show whether any value has been latched by mistake.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] A_LIVE_LO   = 9'h1F0;
  localparam logic [ADDR_W-1:0] A_LIVE_HI   = 9'h1F3;
  localparam logic [ADDR_W-1:0] A_SHADOW_LO = 9'h1F4;
  localparam logic [ADDR_W-1:0] A_SHADOW_HI = 9'h1FB;
  localparam logic [ADDR_W-1:0] A_PHASE_A   = 9'h1FC;
  localparam logic [ADDR_W-1:0] A_PHASE_B   = 9'h1FD;
  localparam logic [ADDR_W-1:0] A_IND_A     = 9'h1FE;
  localparam logic [ADDR_W-1:0] A_IND_B     = 9'h1FF;

  typedef enum logic [2:0] {
    K_RAM, K_LIVE, K_SHADOW, K_PHASE, K_NULL
  } slot_kind_t;

  // Replace an indirect slot by the pointer it names.
  function automatic logic [ADDR_W-1:0] resolve_addr(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] pa,
    input logic [ADDR_W-1:0] pb);
    if (a == A_IND_A)      return pa;
    else if (a == A_IND_B) return pb;
    else                   return a;
  endfunction

  // Classify an already resolved address; an indirect slot left here is null.
  function automatic slot_kind_t classify(input logic [ADDR_W-1:0] a);
    if (a < A_LIVE_LO)        return K_RAM;
    else if (a <= A_LIVE_HI)  return K_LIVE;
    else if (a <= A_SHADOW_HI) return K_SHADOW;
    else if (a <= A_PHASE_B)  return K_PHASE;
    else                      return K_NULL;
  endfunction

  // Index of a shadowed peripheral register for an address in its window.
  function automatic logic [2:0] shadow_index(input logic [ADDR_W-1:0] a);
    logic [3:0] d;
    d = a[3:0] - 4'd4;
    return d[2:0];
  endfunction
endpackage

// File: rtl/rf_pointer.sv
module rf_pointer
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] ptr_a,
  output logic [ADDR_W-1:0] ptr_b,
  output logic [ADDR_W-1:0] src_eff,
  output logic [ADDR_W-1:0] dst_eff,
  output logic [ADDR_W-1:0] wr_eff
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_a <= '0;
      ptr_b <= '0;
    end else begin
      if (ld_en[0]) ptr_a <= ld_val;
      if (ld_en[1]) ptr_b <= ld_val;
    end
  end

  assign src_eff = resolve_addr(src_addr, ptr_a, ptr_b);
  assign dst_eff = resolve_addr(dst_addr, ptr_a, ptr_b);
  assign wr_eff  = resolve_addr(wr_addr,  ptr_a, ptr_b);
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import regfile_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 512,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fg_we,
  input  logic [ADDR_W-1:0]            fg_addr,
  input  logic [DATA_W-1:0]            fg_data,
  input  logic                         bg_we,
  input  logic [ADDR_W-1:0]            bg_addr,
  input  logic [DATA_W-1:0]            bg_data,
  input  logic [ADDR_W-1:0]            rd0_addr,
  input  logic [ADDR_W-1:0]            rd1_addr,
  output logic [DATA_W-1:0]            rd0_data,
  output logic [DATA_W-1:0]            rd1_data,
  output logic [LINE_WORDS*DATA_W-1:0] dline,
  output logic [LINE_WORDS*DATA_W-1:0] iline
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Two write ports; the foreground never targets the hidden cells the
  // background port owns, so no arbitration is needed.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (fg_we) mem[fg_addr] <= fg_data;
      if (bg_we) mem[bg_addr] <= bg_data;
    end
  end

  assign rd0_data = mem[rd0_addr];
  assign rd1_data = mem[rd1_addr];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_line
    assign dline[w*DATA_W +: DATA_W] = mem[int'(A_LIVE_LO) + w];
    assign iline[w*DATA_W +: DATA_W] = mem[int'(A_PHASE_A) + w];
  end
endmodule

// File: rtl/rf_special.sv
module rf_special
  import regfile_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_SHADOW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sh_we,
  input  logic [2:0]                 sh_idx,
  input  logic [DATA_W-1:0]          sh_data,
  output logic [N_SHADOW*DATA_W-1:0] sh_regs
);
  logic [DATA_W-1:0] regs [N_SHADOW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SHADOW; i++) regs[i] <= '0;
    end else if (sh_we) begin
      regs[sh_idx] <= sh_data;
    end
  end

  for (genvar k = 0; k < N_SHADOW; k++) begin : g_flat
    assign sh_regs[k*DATA_W +: DATA_W] = regs[k];
  end
endmodule

// File: rtl/rf_readmux.sv
module rf_readmux
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] eff,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [DATA_W-1:0] live_cnt,
  input  logic [DATA_W-1:0] live_rnd,
  input  logic [DATA_W-1:0] live_ina,
  input  logic [DATA_W-1:0] live_inb,
  input  logic [DATA_W-1:0] phase_a,
  input  logic [DATA_W-1:0] phase_b,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    unique case (classify(eff))
      K_RAM, K_SHADOW: rd_data = ram_data;
      K_LIVE: begin
        unique case (eff[1:0])
          2'd0:    rd_data = live_cnt;
          2'd1:    rd_data = live_rnd;
          2'd2:    rd_data = live_ina;
          default: rd_data = live_inb;
        endcase
      end
      K_PHASE: rd_data = eff[0] ? phase_b : phase_a;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 512,
  parameter int N_SHADOW   = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [8:0]                   src_addr,
  output logic [DATA_W-1:0]            src_data,
  input  logic [8:0]                   dst_addr,
  output logic [DATA_W-1:0]            dst_data,
  input  logic                         wr_en,
  input  logic [8:0]                   wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [DATA_W-1:0]            live_cnt,
  input  logic [DATA_W-1:0]            live_rnd,
  input  logic [DATA_W-1:0]            live_ina,
  input  logic [DATA_W-1:0]            live_inb,
  input  logic [DATA_W-1:0]            phase_a,
  input  logic [DATA_W-1:0]            phase_b,
  output logic [1:0]                   phs_wr_en,
  output logic [DATA_W-1:0]            phs_wr_data,
  output logic [N_SHADOW*DATA_W-1:0]   shadow_regs,
  input  logic [1:0]                   ptr_ld_en,
  input  logic [8:0]                   ptr_ld_val,
  input  logic                         bg_wr_en,
  input  logic                         bg_line,
  input  logic [1:0]                   bg_word,
  input  logic [DATA_W-1:0]            bg_wr_data,
  output logic [LINE_WORDS*DATA_W-1:0] dcache_line,
  output logic [LINE_WORDS*DATA_W-1:0] icache_line
);
  logic [ADDR_W-1:0] ptr_a, ptr_b;
  logic [ADDR_W-1:0] src_eff, dst_eff, wr_eff;
  slot_kind_t        wr_kind;
  logic              ram_we, shadow_we;
  logic [ADDR_W-1:0] bg_addr;
  logic [DATA_W-1:0] ram_rd [2];
  logic [ADDR_W-1:0] rd_eff [2];
  logic [DATA_W-1:0] rd_out [2];

  rf_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_en(ptr_ld_en), .ld_val(ptr_ld_val),
    .src_addr(src_addr), .dst_addr(dst_addr), .wr_addr(wr_addr),
    .ptr_a(ptr_a), .ptr_b(ptr_b),
    .src_eff(src_eff), .dst_eff(dst_eff), .wr_eff(wr_eff)
  );

  // Write decode on the resolved address.
  assign wr_kind   = classify(wr_eff);
  assign ram_we    = wr_en && (wr_kind == K_RAM || wr_kind == K_SHADOW);
  assign shadow_we = wr_en && (wr_kind == K_SHADOW);
  assign phs_wr_en = (wr_en && wr_kind == K_PHASE) ?
                     (wr_eff[0] ? 2'b10 : 2'b01) : 2'b00;
  assign phs_wr_data = wr_data;

  assign bg_addr = (bg_line ? A_PHASE_A : A_LIVE_LO) + {7'd0, bg_word};

  rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .fg_we(ram_we), .fg_addr(wr_eff), .fg_data(wr_data),
    .bg_we(bg_wr_en), .bg_addr(bg_addr), .bg_data(bg_wr_data),
    .rd0_addr(src_eff), .rd1_addr(dst_eff),
    .rd0_data(ram_rd[0]), .rd1_data(ram_rd[1]),
    .dline(dcache_line), .iline(icache_line)
  );

  rf_special #(.DATA_W(DATA_W), .N_SHADOW(N_SHADOW)) u_sh (
    .clk(clk), .rst_n(rst_n), .sh_we(shadow_we),
    .sh_idx(shadow_index(wr_eff)), .sh_data(wr_data), .sh_regs(shadow_regs)
  );

  assign rd_eff[0] = src_eff;
  assign rd_eff[1] = dst_eff;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rf_readmux #(.DATA_W(DATA_W)) u_mux (
      .eff(rd_eff[p]), .ram_data(ram_rd[p]),
      .live_cnt(live_cnt), .live_rnd(live_rnd),
      .live_ina(live_ina), .live_inb(live_inb),
      .phase_a(phase_a), .phase_b(phase_b),
      .rd_data(rd_out[p])
    );
  end

  assign src_data = rd_out[0];
  assign dst_data = rd_out[1];
endmodule

// File: rtl/core_regfile_checker.sv
module core_regfile_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [8:0]   src_addr,
  input logic [31:0]  src_data,
  input logic         wr_en,
  input logic [8:0]   wr_addr,
  input logic [31:0]  wr_data,
  input logic [1:0]   phs_wr_en,
  input logic [255:0] shadow_regs,
  input logic [1:0]   ptr_ld_en,
  input logic [8:0]   ptr_ld_val,
  input logic         bg_wr_en,
  input logic [127:0] dcache_line,
  input logic [127:0] icache_line,
  input logic [8:0]   ptr_a,
  input logic [8:0]   ptr_b
);
  // Direct shadow write seen last edge, captured independently of the design.
  logic        last_hit;
  logic [2:0]  last_idx;
  logic [31:0] last_data;
  logic [31:0] shadow_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_hit  <= 1'b0;
      last_idx  <= '0;
      last_data <= '0;
    end else begin
      last_hit  <= wr_en && wr_addr >= 9'h1F4 && wr_addr <= 9'h1FB;
      last_idx  <= 3'(wr_addr - 9'h1F4);
      last_data <= wr_data;
    end
  end

  assign shadow_word = shadow_regs[32*last_idx +: 32];

  p_live_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bg_wr_en && wr_addr >= 9'h1F0 && wr_addr <= 9'h1F3)
      |=> $stable(dcache_line));

  p_shadow_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |-> shadow_word == last_data);

  p_phase_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phs_wr_en) && (phs_wr_en != 2'b00 -> wr_en));

  p_self_pointer_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_addr == 9'h1FE && ptr_a[8:1] == 8'hFF) |-> src_data == 32'd0);

  p_ptr_a_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld_en[0] |=> ptr_a == $past(ptr_ld_val));

  p_ptr_b_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld_en[1] |=> ptr_b == $past(ptr_ld_val));

  p_icache_private_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_wr_en |=> $stable(icache_line));
endmodule

bind core_regfile core_regfile_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .src_data(src_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .phs_wr_en(phs_wr_en), .shadow_regs(shadow_regs),
  .ptr_ld_en(ptr_ld_en), .ptr_ld_val(ptr_ld_val), .bg_wr_en(bg_wr_en),
  .dcache_line(dcache_line), .icache_line(icache_line),
  .ptr_a(ptr_a), .ptr_b(ptr_b)
);

// File: tb/test_core_regfile.sv
module test_core_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [8:0]   src_addr = '0, dst_addr = '0, wr_addr = '0;
  logic [31:0]  src_data, dst_data;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  live_cnt = '0, live_rnd = '0, live_ina = '0, live_inb = '0;
  logic [31:0]  phase_a = '0, phase_b = '0;
  logic [1:0]   phs_wr_en;
  logic [31:0]  phs_wr_data;
  logic [255:0] shadow_regs;
  logic [1:0]   ptr_ld_en = '0;
  logic [8:0]   ptr_ld_val = '0;
  logic         bg_wr_en = 1'b0, bg_line = 1'b0;
  logic [1:0]   bg_word = '0;
  logic [31:0]  bg_wr_data = '0;
  logic [127:0] dcache_line, icache_line;

  core_regfile i_core_regfile (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [31:0] m_mem [512];
  logic [31:0] m_sh  [8];
  logic [8:0]  m_pa, m_pb;

  function automatic logic [8:0] follow(input logic [8:0] a);
    case (a)
      9'h1FE:  return m_pa;
      9'h1FF:  return m_pb;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] predict(input logic [8:0] a);
    logic [8:0] t;
    t = follow(a);
    if (t >= 9'h1FE)      return 32'd0;
    if (t == 9'h1FC)      return phase_a;
    if (t == 9'h1FD)      return phase_b;
    if (t == 9'h1F0)      return live_cnt;
    if (t == 9'h1F1)      return live_rnd;
    if (t == 9'h1F2)      return live_ina;
    if (t == 9'h1F3)      return live_inb;
    return m_mem[t];
  endfunction

  function automatic logic [1:0] predict_strobe(input logic we, input logic [8:0] a);
    logic [8:0] t;
    t = follow(a);
    if (!we) return 2'b00;
    if (t == 9'h1FC) return 2'b01;
    if (t == 9'h1FD) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [127:0] pack_line(input int base);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) v[32*w +: 32] = m_mem[base + w];
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    logic [255:0] sh;
    for (int k = 0; k < 8; k++) sh[32*k +: 32] = m_sh[k];
    check({req, " shadow"}, shadow_regs, sh);
    check({req, " dline"}, {128'd0, dcache_line}, {128'd0, pack_line(9'h1F0)});
    check({req, " iline"}, {128'd0, icache_line}, {128'd0, pack_line(9'h1FC)});
  endtask

  // One clock: drive, check reads and strobes, clock, update model.
  task automatic step(input string req,
                      input logic we, input logic [8:0] wa, input logic [31:0] wd,
                      input logic [8:0] sa, input logic [8:0] da,
                      input logic bge, input logic bgl, input logic [1:0] bgw,
                      input logic [31:0] bgd,
                      input logic [1:0] ple, input logic [8:0] plv);
    logic [8:0] t;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    src_addr = sa; dst_addr = da;
    bg_wr_en = bge; bg_line = bgl; bg_word = bgw; bg_wr_data = bgd;
    ptr_ld_en = ple; ptr_ld_val = plv;
    live_cnt = $urandom; live_rnd = $urandom; live_ina = $urandom; live_inb = $urandom;
    phase_a = $urandom; phase_b = $urandom;
    #1;
    check({req, " src"}, {224'd0, src_data}, {224'd0, predict(sa)});
    check({req, " dst"}, {224'd0, dst_data}, {224'd0, predict(da)});
    check({req, " phs_en"}, {254'd0, phs_wr_en}, {254'd0, predict_strobe(we, wa)});
    if (phs_wr_en != 2'b00)
      check({req, " phs_data"}, {224'd0, phs_wr_data}, {224'd0, wd});
    @(posedge clk);
    #1;
    t = follow(wa);
    if (we && t < 9'h1FE) begin
      if (t <= 9'h1EF) m_mem[t] = wd;
      else if (t >= 9'h1F4 && t <= 9'h1FB) begin
        m_mem[t] = wd;
        m_sh[t - 9'h1F4] = wd;
      end
    end
    if (bge) m_mem[(bgl ? 9'h1FC : 9'h1F0) + {7'd0, bgw}] = bgd;
    if (ple[0]) m_pa = plv;
    if (ple[1]) m_pb = plv;
  endtask

  task automatic idle_read(input string req, input logic [8:0] sa, input logic [8:0] da);
    step(req, 1'b0, 9'd0, 32'd0, sa, da, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) m_mem[i] = '0;
    for (int k = 0; k < 8; k++) m_sh[k] = '0;
    m_pa = '0; m_pb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state
    check_state("R9 reset");
    idle_read("R9 reset word0", 9'h000, 9'h1EF);
    idle_read("R9 reset ptrs", 9'h1FE, 9'h1FF);

    // R1: plain storage at both ends of its range
    step("R1 wr", 1'b1, 9'h005, 32'hCAFE_0005, 9'h005, 9'h005, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    step("R1 wr hi", 1'b1, 9'h1EF, 32'h1234_5678, 9'h005, 9'h1EF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    idle_read("R1 rd", 9'h1EF, 9'h005);

    // R2: live reads, ignored writes at every live address
    for (int a = 9'h1F0; a <= 9'h1F3; a++)
      step("R2 live wr", 1'b1, 9'(a), 32'hDEAD_0000 + a, 9'(a), 9'h1F0, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    check_state("R2 after");

    // R3: every shadow window address
    for (int a = 9'h1F4; a <= 9'h1FB; a++)
      step("R3 sh wr", 1'b1, 9'(a), 32'hA500_0000 + a, 9'(a), 9'(a), 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    idle_read("R3 sh rd", 9'h1F4, 9'h1FB);
    check_state("R3 after");

    // R4: phase reads and strobes, icache untouched
    step("R4 phs a", 1'b1, 9'h1FC, 32'h0BAD_00AA, 9'h1FC, 9'h1FD, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    step("R4 phs b", 1'b1, 9'h1FD, 32'h0BAD_00BB, 9'h1FD, 9'h1FC, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    check_state("R4 after");

    // R7 + R5: load pointers, then indirect write/read
    step("R7 ld a", 1'b0, 9'd0, 32'd0, 9'h1FE, 9'h1FF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b01, 9'h010);
    step("R7 ld b", 1'b0, 9'd0, 32'd0, 9'h1FE, 9'h1FF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b10, 9'h1F9);
    step("R5 ind wr a", 1'b1, 9'h1FE, 32'h7777_0010, 9'h1FE, 9'h010, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    step("R5 ind wr b", 1'b1, 9'h1FF, 32'h7777_01F9, 9'h1FF, 9'h1F9, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    idle_read("R5 ind rd", 9'h010, 9'h1FF);
    check_state("R5 shadow via ptr");
    step("R5 ld a phase", 1'b0, 9'd0, 32'd0, 9'h1FE, 9'h1FE, 1'b0, 1'b0, 2'd0, 32'd0, 2'b01, 9'h1FD);
    step("R5 ind phase wr", 1'b1, 9'h1FE, 32'h5555_1FFD, 9'h1FE, 9'h1FF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);

    // R6: self-referencing pointers
    step("R6 ld both", 1'b0, 9'd0, 32'd0, 9'h1FE, 9'h1FF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b11, 9'h1FF);
    step("R6 wr null a", 1'b1, 9'h1FE, 32'hFFFF_0001, 9'h1FE, 9'h1FF, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    step("R6 wr null b", 1'b1, 9'h1FF, 32'hFFFF_0002, 9'h1FF, 9'h1FE, 1'b0, 1'b0, 2'd0, 32'd0, 2'b00, 9'd0);
    check_state("R6 after");
    step("R6 ld a 1fe", 1'b0, 9'd0, 32'd0, 9'h1FE, 9'h1FE, 1'b0, 1'b0, 2'd0, 32'd0, 2'b01, 9'h1FE);
    idle_read("R6 rd", 9'h1FE, 9'h1FF);

    // R8: background fills of both lines, with concurrent instruction writes
    for (int w = 0; w < 4; w++) begin
      step("R8 bg d", 1'b1, 9'h1F4 + 9'(w), 32'hC0C0_0000 + w, 9'h1F0, 9'h1F4,
           1'b1, 1'b0, 2'(w), 32'hD000_0000 + w, 2'b00, 9'd0);
      step("R8 bg i", 1'b1, 9'h1FC, 32'hC1C1_0000 + w, 9'h1FC, 9'h020,
           1'b1, 1'b1, 2'(w), 32'hE000_0000 + w, 2'b00, 9'd0);
    end
    check_state("R8 lines");

    // Random mix across all regions
    for (int n = 0; n < 600; n++) begin
      logic [8:0] wa, sa, da, pv;
      int sel;
      sel = $urandom_range(0, 3);
      wa = (sel == 0) ? 9'($urandom_range(0, 511)) : 9'h1F0 + 9'($urandom_range(0, 15));
      sa = (n % 2 == 0) ? wa : 9'($urandom_range(0, 511));
      da = 9'h1F0 + 9'($urandom_range(0, 15));
      pv = ($urandom_range(0, 1) == 1) ? 9'h1F0 + 9'($urandom_range(0, 15)) : 9'($urandom_range(0, 511));
      step("R1 R2 R3 R4 R5 R6 R8 rand", 1'($urandom_range(0, 1)), wa, $urandom, sa, da,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           $urandom, 2'($urandom_range(0, 3)), pv);
      if (n % 50 == 0) check_state("R3 R8 rand state");
    end
    check_state("R3 R8 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule